// File: doc/BRIEF.md
# Interleaved DMA address pattern generator

This block produces the byte-address stream for a single interleaved copy. A frame is described as an ordered list of chunks, and each chunk has its own byte count and its own skip distance. The frame is walked chunk by chunk and then repeated a programmed number of times. For every byte the block emits a source address and a destination address, together with two markers. One marker flags the last byte of a chunk. The other flags the last byte of the whole transfer.

The source and destination sides are set up independently. Each side can hold one fixed address, such as a device FIFO. It can advance contiguously and ignore the skips. Or it can advance and add the chunk's skip after every chunk. These settings cover gathering, scattering, scatter-to-scatter copies and plain linear copies. The chunk table is loaded through a simple write port while the block is idle. A start pulse latches the run parameters and begins the walk. Beats leave over a valid/ready handshake. A done pulse marks the end of the run, and an abort input stops the run at once.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, busy, beat_valid and done are all low.
- R2: Each non-empty chunk produces exactly as many beats as its size. Table entries are walked in index order 0 .. chunks_per_frame-1, and that frame is repeated num_frames times. beat_chunk_end is high only on the last beat of a chunk. beat_xfer_end is high only on the final beat of the transfer.
- R3: A side whose increment flag is 0 presents its base address on every beat, whatever its scatter flag is.
- R4: A side with increment 1 and scatter 0 advances by exactly 1 per beat, including across chunk and frame boundaries, and all gaps are ignored.
- R5: A side with increment 1 and scatter 1 advances by 1 within a chunk. After the last byte of a chunk its next address is the last address + 1 + that chunk's gap, and this also holds between the last chunk of a frame and the first chunk of the next frame.
- R6: A chunk of size 0 emits no beats, but its gap is still added on a side with increment 1 and scatter 1.
- R7: If num_frames is 0, chunks_per_frame is 0, or every used entry has size 0, done is high in the cycle after start, and no beat and no busy cycle occurs.
- R8: While beat_valid is high and beat_ready is low, the beat outputs hold their values. Nothing advances without a handshake.
- R9: done is a one-cycle pulse in the cycle after the final beat is accepted, and busy is low in that cycle.
- R10: A start pulse while busy is ignored, and table writes while busy are ignored. Neither changes the running transfer or later ones.
- R11: abort returns the block to idle in the next cycle. It drops beat_valid and gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Chunk table write strobe (idle only) |
| tbl_idx | input | 3 | Table entry index |
| tbl_size | input | 16 | Chunk byte count |
| tbl_gap | input | 16 | Skip distance after the chunk |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| src_inc | input | 1 | Source address advances |
| src_scat | input | 1 | Source applies gaps |
| dst_inc | input | 1 | Destination address advances |
| dst_scat | input | 1 | Destination applies gaps |
| num_frames | input | 16 | Frame repeat count |
| chunks_per_frame | input | 4 | Entries per frame; values above 8 act as 8 |
| start | input | 1 | Begin a transfer (idle only) |
| abort | input | 1 | Synchronous cancel |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer accepts beat |
| beat_src | output | 32 | Source byte address |
| beat_dst | output | 32 | Destination byte address |
| beat_chunk_end | output | 1 | Last byte of chunk |
| beat_xfer_end | output | 1 | Last byte of transfer |
| done | output | 1 | Transfer complete pulse |

## Verification
A start sampled at a rising edge makes busy and the first beat visible in the following cycle. An empty request instead raises done in that cycle. A handshake at an edge shows the next beat one cycle later. A skipped zero-size chunk costs one cycle with beat_valid low. done appears one cycle after the edge that accepted the final beat, and abort takes effect one cycle after the edge that sampled it. The bench drives inputs 5 ns after the rising edge and compares every output at the falling edge, against a queue of expected beats built when start is seen. It pops the queue on each handshake and expects done exactly one sample after the final pop.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_LEN_W   = 16;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_FRM_W   = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ilv_state_e;
endpackage

// File: rtl/ilv_table.sv
module ilv_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LEN_W-1:0] wr_size,
  input  logic [LEN_W-1:0] wr_gap,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [CNT_W-1:0] lim,
  output logic [LEN_W-1:0] rd_size,
  output logic [LEN_W-1:0] rd_gap,
  output logic [IDX_W-1:0] last_nz,
  output logic             any_nz
);
  logic [LEN_W-1:0] size_q [ENTRIES];
  logic [LEN_W-1:0] gap_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        size_q[e] <= '0;
        gap_q[e]  <= '0;
      end
    end else if (wr_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_idx == IDX_W'(e)) begin
          size_q[e] <= wr_size;
          gap_q[e]  <= wr_gap;
        end
      end
    end
  end

  assign rd_size = size_q[rd_idx];
  assign rd_gap  = gap_q[rd_idx];

  // highest used entry holding a non-zero size
  always_comb begin
    any_nz  = 1'b0;
    last_nz = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if ((CNT_W'(e) < lim) && (size_q[e] != '0)) begin
        any_nz  = 1'b1;
        last_nz = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/ilv_side_addr.sv
module ilv_side_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              inc_in,
  input  logic              scat_in,
  input  logic              step_byte,
  input  logic              step_gap,
  input  logic [LEN_W-1:0]  gap,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              inc_q, inc_d, scat_q, scat_d;

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    scat_d = scat_q;
    if (load) begin
      addr_d = start_addr;
      inc_d  = inc_in;
      scat_d = scat_in;
    end else begin
      if (step_byte && inc_q)
        addr_d = addr_d + ADDR_W'(1);
      if (step_gap && inc_q && scat_q)
        addr_d = addr_d + ADDR_W'(gap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
      scat_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
      scat_q <= scat_d;
    end
  end

  assign addr = addr_q;

  AST_FIXED_SIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc_q) |=> $stable(addr_q)); // R3
  AST_CONTIG_IGNORES_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && inc_q && !scat_q && !step_byte) |=> $stable(addr_q)); // R4
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned FRM_W   = DEF_FRM_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [LEN_W-1:0]  tbl_size,
  input  logic [LEN_W-1:0]  tbl_gap,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic              src_inc,
  input  logic              src_scat,
  input  logic              dst_inc,
  input  logic              dst_scat,
  input  logic [FRM_W-1:0]  num_frames,
  input  logic [CNT_W-1:0]  chunks_per_frame,
  input  logic              start,
  input  logic              abort,
  output logic              busy,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_src,
  output logic [ADDR_W-1:0] beat_dst,
  output logic              beat_chunk_end,
  output logic              beat_xfer_end,
  output logic              done
);
  ilv_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [FRM_W-1:0] frm_q, frm_d, numf_q, numf_d;
  logic [CNT_W-1:0] flen_q, flen_d, flen_in, lim;
  logic             done_q, done_d;

  logic [LEN_W-1:0] cur_size, cur_gap;
  logic [IDX_W-1:0] last_nz;
  logic             any_nz, run, hs, chunk_end, last_frame, xfer_end;
  logic             wrap, adv, finish, launch, empty_req;

  assign flen_in = (chunks_per_frame > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : chunks_per_frame;
  assign run     = (state_q == ST_RUN);
  assign lim     = run ? flen_q : flen_in;

  ilv_table #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we && !run), .wr_idx(tbl_idx), .wr_size(tbl_size), .wr_gap(tbl_gap),
    .rd_idx(idx_q), .lim(lim),
    .rd_size(cur_size), .rd_gap(cur_gap), .last_nz(last_nz), .any_nz(any_nz)
  );

  assign beat_valid = run && (cur_size != '0);
  assign hs         = beat_valid && beat_ready;
  assign chunk_end  = (cnt_q == cur_size - LEN_W'(1));
  assign last_frame = (frm_q == numf_q - FRM_W'(1));
  assign xfer_end   = chunk_end && last_frame && (idx_q == last_nz);
  assign wrap       = (CNT_W'(idx_q) == flen_q - CNT_W'(1));
  assign adv        = run && ((hs && chunk_end) || (cur_size == '0));
  assign finish     = hs && xfer_end;
  assign launch     = !run && start && !abort;
  assign empty_req  = (num_frames == '0) || (flen_in == '0) || !any_nz;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    frm_d   = frm_q;
    numf_d  = numf_q;
    flen_d  = flen_q;
    done_d  = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
    end else if (launch) begin
      numf_d = num_frames;
      flen_d = flen_in;
      idx_d  = '0;
      cnt_d  = '0;
      frm_d  = '0;
      if (empty_req) done_d  = 1'b1;
      else           state_d = ST_RUN;
    end else if (run) begin
      if (hs && !chunk_end) cnt_d = cnt_q + LEN_W'(1);
      if (adv) begin
        cnt_d = '0;
        if (wrap) begin
          idx_d = '0;
          frm_d = frm_q + FRM_W'(1);
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      if (finish) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      frm_q   <= '0;
      numf_q  <= '0;
      flen_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      frm_q   <= frm_d;
      numf_q  <= numf_d;
      flen_q  <= flen_d;
      done_q  <= done_d;
    end
  end

  ilv_side_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(launch), .start_addr(src_base),
    .inc_in(src_inc), .scat_in(src_scat), .step_byte(hs && !abort),
    .step_gap(adv && !abort), .gap(cur_gap), .addr(beat_src)
  );

  ilv_side_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(launch), .start_addr(dst_base),
    .inc_in(dst_inc), .scat_in(dst_scat), .step_byte(hs && !abort),
    .step_gap(adv && !abort), .gap(cur_gap), .addr(beat_dst)
  );

  assign beat_chunk_end = beat_valid && chunk_end;
  assign beat_xfer_end  = beat_valid && xfer_end;
  assign busy           = run;
  assign done           = done_q;

  AST_END_IMPLIES_CHUNK_END: assert property (@(posedge clk) disable iff (!rst_n)
    beat_xfer_end |-> beat_chunk_end); // R2
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !abort && num_frames == '0) |=> (done && !busy && !beat_valid)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && !abort) |=>
      (beat_valid && $stable(beat_src) && $stable(beat_dst) && $stable(beat_chunk_end))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_xfer_end && !abort) |=> (done && !busy)); // R9
  AST_BUSY_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && !(beat_valid && beat_ready && beat_xfer_end)) |=> (busy && !done)); // R10
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !beat_valid && !done)); // R11
endmodule

// File: tb/test_ilv_addr_gen.sv
`timescale 1ns/1ps
module test_ilv_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [2:0]  tbl_idx;
  logic [15:0] tbl_size, tbl_gap;
  logic [31:0] src_base, dst_base;
  logic        src_inc, src_scat, dst_inc, dst_scat;
  logic [15:0] num_frames;
  logic [3:0]  chunks_per_frame;
  logic        start, abort;
  logic        busy, beat_valid, beat_ready;
  logic [31:0] beat_src, beat_dst;
  logic        beat_chunk_end, beat_xfer_end, done;

  always #10 clk = ~clk;

  ilv_addr_gen i_ilv_addr_gen (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_size(tbl_size),
    .tbl_gap(tbl_gap), .src_base(src_base), .dst_base(dst_base), .src_inc(src_inc),
    .src_scat(src_scat), .dst_inc(dst_inc), .dst_scat(dst_scat), .num_frames(num_frames),
    .chunks_per_frame(chunks_per_frame), .start(start), .abort(abort), .busy(busy),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_src(beat_src),
    .beat_dst(beat_dst), .beat_chunk_end(beat_chunk_end), .beat_xfer_end(beat_xfer_end),
    .done(done)
  );

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] d;
    logic        ce;
    logic        xe;
  } beat_t;

  beat_t       exp_q[$];
  logic [15:0] sh_size [8];
  logic [15:0] sh_gap  [8];
  int          n_vec = 0;
  int          n_bad = 0;
  logic        done_arm = 1'b0;
  logic        stall_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  string       cur_tag = "R1";
  logic        finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
    n_vec++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, expv, $time);
    end
  endtask

  task automatic build_model();
    logic [31:0] s, d;
    int          flen, anyv;
    beat_t       b;
    exp_q.delete();
    flen = (chunks_per_frame > 8) ? 8 : int'(chunks_per_frame);
    anyv = 0;
    for (int i = 0; i < flen; i++) if (sh_size[i] != 0) anyv = 1;
    if (num_frames == 0 || flen == 0 || anyv == 0) begin
      done_arm = 1'b1;
      return;
    end
    s = src_base;
    d = dst_base;
    for (int f = 0; f < int'(num_frames); f++) begin
      for (int i = 0; i < flen; i++) begin
        for (int k = 0; k < int'(sh_size[i]); k++) begin
          b.s = s; b.d = d; b.ce = (k == int'(sh_size[i]) - 1); b.xe = 1'b0;
          exp_q.push_back(b);
          if (src_inc) s = s + 32'd1;
          if (dst_inc) d = d + 32'd1;
        end
        if (src_inc && src_scat) s = s + 32'(sh_gap[i]);
        if (dst_inc && dst_scat) d = d + 32'(sh_gap[i]);
      end
    end
    b = exp_q[$];
    b.xe = 1'b1;
    exp_q[exp_q.size()-1] = b;
  endtask

  // reference comparison at every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9 done", {31'd0, done}, {31'd0, done_arm});
      done_arm = 1'b0;
      check({cur_tag, " busy"}, {31'd0, busy}, {31'd0, exp_q.size() != 0});
      if (beat_valid) begin
        if (exp_q.size() == 0) begin
          check({cur_tag, " spurious beat"}, 32'd1, 32'd0);
        end else begin
          check({cur_tag, " src"}, beat_src, exp_q[0].s);
          check({cur_tag, " dst"}, beat_dst, exp_q[0].d);
          check("R2 chunk_end", {31'd0, beat_chunk_end}, {31'd0, exp_q[0].ce});
          check("R2 xfer_end", {31'd0, beat_xfer_end}, {31'd0, exp_q[0].xe});
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      beat_ready = stall_mode ? lfsr[0] : 1'b1;
      if (abort) begin
        exp_q.delete();
      end else begin
        if (beat_valid && beat_ready && exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) done_arm = 1'b1;
        end
        if (tbl_we && !busy) begin
          sh_size[tbl_idx] = tbl_size;
          sh_gap[tbl_idx]  = tbl_gap;
        end
        if (start && !busy) build_model();
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic wr_entry(input int idx, input int sz, input int gp);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_size = 16'(sz); tbl_gap = 16'(gp);
    step();
    tbl_we = 1'b0;
  endtask

  task automatic go(input logic [31:0] sb, input logic [31:0] db, input logic si, input logic ss,
                    input logic di, input logic ds, input int nf, input int cl);
    src_base = sb; dst_base = db; src_inc = si; src_scat = ss; dst_inc = di; dst_scat = ds;
    num_frames = 16'(nf); chunks_per_frame = 4'(cl);
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic drain();
    while (busy || exp_q.size() != 0) step();
    step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin sh_size[i] = '0; sh_gap[i] = '0; end
    rst_n = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_size = '0; tbl_gap = '0;
    src_base = '0; dst_base = '0; src_inc = 1'b0; src_scat = 1'b0; dst_inc = 1'b0;
    dst_scat = 1'b0; num_frames = '0; chunks_per_frame = '0; start = 1'b0; abort = 1'b0;
    beat_ready = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 valid", {31'd0, beat_valid}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    step();

    // scattered source, contiguous destination, two frames
    cur_tag = "R5";
    wr_entry(0, 3, 4); wr_entry(1, 1, 0); wr_entry(2, 2, 7);
    go(32'h1000, 32'h8000, 1, 1, 1, 0, 2, 3);
    drain();

    // fixed source (scatter flag ignored), scattered destination
    cur_tag = "R3";
    go(32'h4000_0000, 32'h200, 0, 1, 1, 1, 1, 3);
    drain();

    // both sides contiguous, three frames
    cur_tag = "R4";
    go(32'h10, 32'h9000, 1, 0, 1, 0, 3, 2);
    drain();

    // zero-size chunks in the middle and at the end of a frame
    cur_tag = "R6";
    wr_entry(0, 2, 5); wr_entry(1, 0, 9); wr_entry(2, 1, 3); wr_entry(3, 0, 6);
    go(32'h300, 32'h700, 1, 1, 1, 1, 2, 4);
    drain();

    // empty requests
    cur_tag = "R7";
    go(32'h0, 32'h0, 1, 1, 1, 1, 0, 3);
    drain();
    go(32'h0, 32'h0, 1, 1, 1, 1, 4, 0);
    drain();
    wr_entry(0, 0, 2); wr_entry(1, 0, 2);
    go(32'h0, 32'h0, 1, 1, 1, 1, 5, 2);
    drain();

    // back-pressure
    cur_tag = "R8";
    wr_entry(0, 3, 4); wr_entry(1, 1, 0); wr_entry(2, 2, 7);
    stall_mode = 1'b1;
    go(32'h5000, 32'h6000, 1, 1, 1, 1, 3, 3);
    drain();
    stall_mode = 1'b0;

    // start and table writes while busy
    cur_tag = "R10";
    go(32'h100, 32'h900, 1, 1, 1, 0, 2, 3);
    step(); step();
    go(32'hDEAD_0000, 32'hBEEF_0000, 0, 0, 0, 0, 7, 1);
    wr_entry(1, 9, 9);
    drain();
    go(32'h40, 32'h80, 1, 1, 1, 1, 2, 2);
    drain();

    // abort mid-run, then a clean run
    cur_tag = "R11";
    go(32'hA00, 32'hB00, 1, 1, 1, 1, 4, 3);
    step(); step(); step();
    abort = 1'b1;
    step();
    abort = 1'b0;
    step();
    go(32'hC00, 32'hD00, 1, 0, 1, 1, 1, 3);
    drain();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired with tag %s", cur_tag);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule